// File: doc/BRIEF.md
# Pre-boot Security Lock and Debug Gate

This block decides whether an on-chip debug port may reach the processor and its program memory after a chip reset. For a fixed number of processor clock cycles after reset leaves its active state, the debug port is held off completely. A read-only status bit tells firmware that this window is still open, so that early boot code knows it can act before any debugger is able to interfere.

The block also holds a security lock bit. Software can set it through a one-register write port but can never clear it. Only a chip reset clears it. While the lock is set, the one debug operation still allowed is a bulk flash erase, and external reads of program code are refused. A locked part is therefore freed only by a global erase followed by a reset. Each debug request gets either a grant or a deny in the same cycle, so a requester never waits for an answer that will not come.

Top module: `boot_guard`

## Requirements
- R1: After reset is released, the pre-boot status (read bit 1 of `reg_rd_data`, also `preboot`) is 1 for exactly PREBOOT_CYCLES (default 60) clock cycles. It then goes to 0 and stays 0 until the next reset.
- R2: While pre-boot is active, every debug request is denied and none is granted, whatever the values of `dbg_en` and `dbg_bulk_erase`.
- R3: After pre-boot, with the lock clear and `dbg_en` high, every debug request is granted. With `dbg_en` low, every debug request is denied.
- R4: Reset clears the lock bit (read bit 0 of `reg_rd_data`). All read bits other than bits 0 and 1 read 0.
- R5: A write with bit 0 of `reg_wr_data` set to 1 sets the lock on the next clock edge. A write with bit 0 at 0 leaves the lock unchanged.
- R6: While the lock is set and pre-boot is over, a request with `dbg_bulk_erase`=1 and `dbg_en`=1 is granted. A request with `dbg_bulk_erase`=0 is denied.
- R7: `code_rd_ok` is 1 only when pre-boot is over, `dbg_en` is 1 and the lock is clear.
- R8: Once set, the lock stays set through any writes and through granted bulk erases. Only reset clears it.
- R9: `dbg_grant` and `dbg_deny` are combinational. With `dbg_req`=1, exactly one of them is 1 in the same cycle. With `dbg_req`=0, both are 0.
- R10: Writes to bit 1 of `reg_wr_data` have no effect on the pre-boot status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | REG_W | Write data; bit 0 sets the lock |
| reg_rd_data | output | REG_W | Bit 0 lock, bit 1 pre-boot status, others 0 |
| preboot | output | 1 | Pre-boot window active |
| dbg_en | input | 1 | Debug port enabled |
| dbg_req | input | 1 | Debug operation request |
| dbg_bulk_erase | input | 1 | Request is a bulk flash erase |
| dbg_grant | output | 1 | Request accepted this cycle |
| dbg_deny | output | 1 | Request refused this cycle |
| code_rd_ok | output | 1 | External program-code reads permitted |

## Verification
An off-by-one in the window counter shows at the status bit and at the debug grant on the 60th or 61st cycle after reset. The bench therefore counts the high cycles of the status bit exactly and probes a request at the first cycle after the window. A lock that drops or fails to set shows in the same cycle as a wrongly granted non-erase request, or as `code_rd_ok` going high. The bench probes both right after the write, after zero writes and after a granted erase. A counter that wraps instead of saturating would raise the status bit again, and a long idle stretch after the window exposes that.

// File: rtl/boot_guard_pkg.sv
// Package: shared field positions for the boot guard register.
// Assumes a register at least two bits wide.
package boot_guard_pkg;
    localparam int LOCK_POS = 0;   // write-ones lock bit
    localparam int PRE_POS  = 1;   // read-only pre-boot status
endpackage

// File: rtl/boot_guard_timer.sv
// Pre-boot window counter: counts clocks after reset up to CYCLES, then saturates.
// Assumes CYCLES >= 1; window flag is high while the count is below CYCLES.
module boot_guard_timer #(
    parameter int CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    output logic in_window
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    // Count up from reset and hold at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    // Window is open until the terminal count is reached.
    always_comb in_window = (cnt_q != LAST);
endmodule

// File: rtl/boot_guard_lock.sv
// Set-only security lock: a write of one sets it, only reset clears it.
// Assumes the write strobe is synchronous to clk.
module boot_guard_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    output logic locked
);
    // Sticky lock flop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (set_req)
            locked <= 1'b1;
    end
endmodule

// File: rtl/boot_guard_arb.sv
// Access decision: grants or denies debug requests in the same cycle.
// Assumes inputs are stable around the clock edge; purely combinational.
module boot_guard_arb (
    input  logic in_window,
    input  logic locked,
    input  logic dbg_en,
    input  logic dbg_req,
    input  logic dbg_bulk_erase,
    output logic dbg_grant,
    output logic dbg_deny,
    output logic code_rd_ok
);
    logic port_open;

    // Decide port availability, then answer the request.
    always_comb begin
        port_open  = dbg_en && !in_window;
        dbg_grant  = dbg_req && port_open && (!locked || dbg_bulk_erase);
        dbg_deny   = dbg_req && !dbg_grant;
        code_rd_ok = port_open && !locked;
    end
endmodule

// File: rtl/boot_guard.sv
// Boot guard top: pre-boot debug blackout, set-only security lock and debug gate.
// Assumes a synchronous active-low reset and REG_W >= 2.
module boot_guard
    import boot_guard_pkg::*;
#(
    parameter int PREBOOT_CYCLES = 60,
    parameter int REG_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             preboot,
    input  logic             dbg_en,
    input  logic             dbg_req,
    input  logic             dbg_bulk_erase,
    output logic             dbg_grant,
    output logic             dbg_deny,
    output logic             code_rd_ok
);
    logic locked;
    logic in_window;
    logic unused_wr_bits;

    boot_guard_timer #(.CYCLES(PREBOOT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (in_window)
    );

    boot_guard_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (reg_wr_en && reg_wr_data[LOCK_POS]),
        .locked  (locked)
    );

    boot_guard_arb u_arb (
        .in_window      (in_window),
        .locked         (locked),
        .dbg_en         (dbg_en),
        .dbg_req        (dbg_req),
        .dbg_bulk_erase (dbg_bulk_erase),
        .dbg_grant      (dbg_grant),
        .dbg_deny       (dbg_deny),
        .code_rd_ok     (code_rd_ok)
    );

    // Only the lock bit of the write data is used.
    assign unused_wr_bits = ^{reg_wr_data[REG_W-1:1]};

    // Assemble the read view of the register.
    always_comb begin
        reg_rd_data           = '0;
        reg_rd_data[LOCK_POS] = locked;
        reg_rd_data[PRE_POS]  = in_window;
        preboot               = in_window;
    end
endmodule

// File: rtl/boot_guard_chk.sv
// Checker for boot_guard: port-level properties, bound into every instance.
// Assumes the synchronous active-low reset of the top.
module boot_guard_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [REG_W-1:0] reg_wr_data,
    input logic [REG_W-1:0] reg_rd_data,
    input logic             preboot,
    input logic             dbg_req,
    input logic             dbg_bulk_erase,
    input logic             dbg_grant,
    input logic             dbg_deny,
    input logic             code_rd_ok
);
    // R2: no grant inside the window
    p_no_grant_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        preboot |-> !dbg_grant);
    // R1: window never reopens without reset
    p_window_stays_closed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !preboot |=> !preboot);
    // R8: lock is sticky
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[0] |=> reg_rd_data[0]);
    // R5: a write of one sets the lock
    p_lock_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_data[0]) |=> reg_rd_data[0]);
    // R6: locked grants are bulk erases only
    p_locked_erase_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[0] && dbg_grant) |-> dbg_bulk_erase);
    // R7: no code read while locked
    p_no_code_read_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_data[0] |-> !code_rd_ok);
    // R9: exactly one answer to each request, none otherwise
    p_one_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({dbg_grant, dbg_deny}) == (dbg_req ? 1 : 0));
endmodule

bind boot_guard boot_guard_chk #(.REG_W(REG_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr_en      (reg_wr_en),
    .reg_wr_data    (reg_wr_data),
    .reg_rd_data    (reg_rd_data),
    .preboot        (preboot),
    .dbg_req        (dbg_req),
    .dbg_bulk_erase (dbg_bulk_erase),
    .dbg_grant      (dbg_grant),
    .dbg_deny       (dbg_deny),
    .code_rd_ok     (code_rd_ok)
);

// File: tb/boot_guard_tb.sv
// Directed bench for boot_guard: one task per scenario, each checking itself.
module boot_guard_tb_top;
    localparam int N = 60;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_wr_en = 1'b0;
    logic [W-1:0] reg_wr_data = '0;
    logic [W-1:0] reg_rd_data;
    logic         preboot;
    logic         dbg_en = 1'b0;
    logic         dbg_req = 1'b0;
    logic         dbg_bulk_erase = 1'b0;
    logic         dbg_grant, dbg_deny, code_rd_ok;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    boot_guard #(.PREBOOT_CYCLES(N), .REG_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .preboot(preboot), .dbg_en(dbg_en),
        .dbg_req(dbg_req), .dbg_bulk_erase(dbg_bulk_erase),
        .dbg_grant(dbg_grant), .dbg_deny(dbg_deny), .code_rd_ok(code_rd_ok)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reset and release at a falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        reg_wr_en = 1'b0; dbg_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One register write, then back to the falling edge after it lands.
    task automatic reg_write(input logic [W-1:0] d);
        reg_wr_en = 1'b1; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_data = '0;
    endtask

    // Apply a request and sample the same-cycle answer: returns {grant, deny}.
    task automatic probe(input bit en, input bit erase, output logic [1:0] ans);
        dbg_en = en; dbg_bulk_erase = erase; dbg_req = 1'b1;
        #1;
        ans = {dbg_grant, dbg_deny};
        dbg_req = 1'b0;
        #1;
    endtask

    task automatic t_window();
        int highs = 0;
        logic [1:0] ans;
        do_reset();
        check(reg_rd_data == 8'h02, "R4 reset read", reg_rd_data, 2);
        for (int i = 0; i < N + 20; i++) begin
            if (reg_rd_data[1]) highs++;
            if (i == 3) begin
                probe(1'b1, 1'b0, ans);
                check(ans == 2'b01, "R2 normal req in window", ans, 1);
                probe(1'b1, 1'b1, ans);
                check(ans == 2'b01, "R2 erase req in window", ans, 1);
                check(code_rd_ok == 1'b0, "R7 no read in window", code_rd_ok, 0);
            end
            if (i == 5) reg_write(8'h02);   // R10 write to status bit
            else @(negedge clk);
        end
        check(highs == N, "R1 window length", highs, N);
        check(preboot == 1'b0, "R10 status unaffected", preboot, 0);
        #1;
        check(dbg_grant == 1'b0 && dbg_deny == 1'b0, "R9 idle no answer",
              {dbg_grant, dbg_deny}, 0);
    endtask

    task automatic t_exact_edge();
        logic [1:0] ans;
        do_reset();
        repeat (N - 1) @(negedge clk);
        check(preboot == 1'b1, "R1 last window cycle", preboot, 1);
        probe(1'b1, 1'b0, ans);
        check(ans == 2'b01, "R2 last window cycle denied", ans, 1);
        @(negedge clk);
        check(preboot == 1'b0, "R1 first open cycle", preboot, 0);
        probe(1'b1, 1'b0, ans);
        check(ans == 2'b10, "R3 first open cycle granted", ans, 2);
        probe(1'b0, 1'b1, ans);
        check(ans == 2'b01, "R3 disabled denied", ans, 1);
        dbg_en = 1'b1; #1;
        check(code_rd_ok == 1'b1, "R7 read allowed unlocked", code_rd_ok, 1);
        repeat (3000) @(negedge clk);
        check(preboot == 1'b0, "R1 saturates", preboot, 0);
    endtask

    task automatic t_lock();
        logic [1:0] ans;
        do_reset();
        repeat (N + 2) @(negedge clk);
        reg_write(8'hFE);
        check(reg_rd_data[0] == 1'b0, "R5 zero write no lock", reg_rd_data[0], 0);
        reg_write(8'h01);
        check(reg_rd_data[0] == 1'b1, "R5 one write sets lock", reg_rd_data[0], 1);
        probe(1'b1, 1'b0, ans);
        check(ans == 2'b01, "R6 locked normal denied", ans, 1);
        probe(1'b1, 1'b1, ans);
        check(ans == 2'b10, "R6 locked erase granted", ans, 2);
        dbg_en = 1'b1; #1;
        check(code_rd_ok == 1'b0, "R7 read blocked locked", code_rd_ok, 0);
        dbg_req = 1'b1; dbg_bulk_erase = 1'b1;
        @(negedge clk);
        dbg_req = 1'b0;
        reg_write(8'h00);
        check(reg_rd_data[0] == 1'b1, "R8 lock kept after erase and zero write",
              reg_rd_data[0], 1);
        do_reset();
        check(reg_rd_data[0] == 1'b0, "R4 reset clears lock", reg_rd_data[0], 0);
    endtask

    task automatic t_lock_in_window();
        logic [1:0] ans;
        do_reset();
        @(negedge clk);
        reg_write(8'h01);
        check(reg_rd_data[0] == 1'b1, "R5 set during window", reg_rd_data[0], 1);
        repeat (N) @(negedge clk);
        probe(1'b1, 1'b0, ans);
        check(ans == 2'b01, "R6 locked after window denied", ans, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_window();
        t_exact_edge();
        t_lock();
        t_lock_in_window();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule